// File: doc/BRIEF.md
# Low-Speed USB Serial Receiver

This block is the receive front end of a low-speed USB device. It takes the raw D+ and D- line levels and passes them through a two-flop synchroniser. It runs from a clock at a fixed multiple of the bit rate, ten clocks per bit by default. While idle it watches for the line to leave J. If the line drops into K, the block hunts through the sync pattern. It recentres its sampling phase on every J-to-K edge of that pattern and takes one sample per bit, half a bit after the last edge. The pattern is complete once two K samples arrive in a row.

After sync, the block NRZI-decodes the D- samples and discards stuffed bits. It assembles bytes least significant bit first and pushes each finished byte into a small receive FIFO. The FIFO is read through a valid/ready stream. A byte stays on `rx_data` with `rx_valid` high until the consumer takes it with `rx_ready`. The receiver itself cannot be stalled. If the consumer falls behind and the FIFO is full when a byte completes, the byte is lost, an overflow pulse is raised and the rest of that packet is discarded.

An SE0 ends a packet. SE0 is not honoured on the first bit of a byte, so a trailing hub dribble bit does no harm. A drop straight from J to SE0 is taken as a keep-alive pulse and counted. An SE0 inside the sync pattern is reported as an error.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, `rx_valid`, `eop`, `ovf_err` and `sync_err` are low and `ka_cnt` is zero.
- R2: Line states are written {D+,D-}: J = {0,1}, K = {1,0}, SE0 = {0,0}. In the idle hunt, a J-to-K change starts sync. During sync every J-to-K edge restarts the bit phase. Two consecutive K samples end sync, and the second of them is the NRZI reference for the first data bit.
- R3: One bit lasts OSR clocks. A bit is sampled OSR/2 clocks after the last phase restart and every OSR clocks after that. Sync bits of uneven length are still followed correctly.
- R4: A data bit is 1 when the D- sample equals the previous one and 0 when it differs. Bits fill a byte from bit 0 upward, and bytes leave the FIFO in arrival order.
- R5: After six consecutive decoded 1s (the last sync bit counts as the first of them), the next bit is dropped and the run count restarts. A decoded 0 also restarts the count.
- R6: An SE0 sampled at bit positions 1 to 7 of a byte ends the packet. It raises `eop` for one clock, discards the partial byte and returns to the idle hunt. An SE0 sampled at position 0 is decoded as an ordinary bit through D-, so one dribble bit before the end of the packet is tolerated.
- R7: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` holds its value.
- R8: If a byte completes while the FIFO is full, `ovf_err` pulses once and the byte is dropped. No further bytes of that packet are accepted, no `eop` is raised for it, and the receiver waits for SE0 before it hunts again.
- R9: A change from J straight to SE0 while hunting raises `ka_cnt` by one, saturating at 2^KA_W-1. It produces no bytes and no `eop`.
- R10: An SE0 sampled during sync pulses `sync_err`, returns to the hunt and produces no `eop`.
- R11: At most one of `eop`, `ovf_err` and `sync_err` is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at OSR times the bit rate |
| rst_n | input | 1 | Active-low reset |
| dp_i | input | 1 | D+ line level, asynchronous |
| dm_i | input | 1 | D- line level, asynchronous |
| rx_valid | output | 1 | A received byte is available |
| rx_ready | input | 1 | Consumer accepts the byte on `rx_data` |
| rx_data | output | 8 | Oldest received byte |
| eop | output | 1 | One-clock pulse at end of packet |
| ovf_err | output | 1 | One-clock pulse when a byte is lost to a full FIFO |
| sync_err | output | 1 | One-clock pulse on SE0 during sync |
| ka_cnt | output | KA_W | Saturating count of keep-alive pulses |

## Verification
The bench builds the block with OSR = 10, a four-entry FIFO and a two-bit keep-alive counter. The shallow FIFO lets a six-byte packet sent against a stalled consumer reach the overflow path. The narrow counter reaches saturation after three keep-alive pulses. Every byte value from 0 to 255 is sent in four-byte packets, with the consumer stalled on alternate packets so that the stream holds full packets under back-pressure. Dedicated packets cover long runs of ones that force stuffing at byte edges, a dribble bit, SE0 in the middle of a byte, SE0 inside sync, and sync bits of stretched length.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  // line state written {D+, D-}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_KALIVE,
    ST_SYNC,
    ST_DATA,
    ST_DRAIN
  } rx_state_t;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned STUFF_RUN = 6;
endpackage

// File: rtl/usb_ls_rx_sync.sv
module usb_ls_rx_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= WIDTH'(1);   // reset to J
      else if (s == 0) stage[s] <= d_i;
      else stage[s] <= stage[s-1];
    end
  end

  assign q_o = stage[STAGES-1];
endmodule

// File: rtl/usb_ls_rx_fifo.sv
module usb_ls_rx_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic             full_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] data_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr, rd_ptr;

  assign full_o  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign valid_o = (wr_ptr != rd_ptr);
  assign data_o  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_i && !full_o) wr_ptr <= wr_ptr + 1'b1;
      if (valid_o && ready_i) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[wr_ptr[AW-1:0]] <= push_data_i;
  end
endmodule

// File: rtl/usb_ls_rx_core.sv
module usb_ls_rx_core
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned OSR  = 10,
  parameter int unsigned KA_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  line_t                line_i,
  input  logic                 full_i,
  output logic                 push_o,
  output logic [BYTE_BITS-1:0] byte_o,
  output logic                 eop_o,
  output logic                 ovf_o,
  output logic                 sync_err_o,
  output logic [KA_W-1:0]      ka_cnt_o
);
  localparam int unsigned PH_W   = $clog2(OSR);
  localparam int unsigned HALF   = OSR / 2;
  localparam int unsigned RUN_W  = $clog2(STUFF_RUN + 1);
  localparam int unsigned BIT_W  = $clog2(BYTE_BITS);
  localparam logic [KA_W-1:0] KA_MAX = '1;

  rx_state_t            st;
  line_t                ln_q;
  logic [PH_W-1:0]      ph;
  logic                 prev_dm;
  logic                 last_k;
  logic [RUN_W-1:0]     ones;
  logic [BIT_W-1:0]     bpos;
  logic [BYTE_BITS-1:0] shreg;

  logic                 smp, jk_edge, dbit;
  logic [BYTE_BITS-1:0] nbyte;

  always_comb begin
    smp     = (ph == PH_W'(HALF));
    jk_edge = (ln_q == LN_J) && (line_i == LN_K);
    dbit    = (line_i[0] == prev_dm);
    nbyte   = {dbit, shreg[BYTE_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_HUNT;
      ln_q       <= LN_J;
      ph         <= '0;
      prev_dm    <= 1'b0;
      last_k     <= 1'b0;
      ones       <= '0;
      bpos       <= '0;
      shreg      <= '0;
      push_o     <= 1'b0;
      byte_o     <= '0;
      eop_o      <= 1'b0;
      ovf_o      <= 1'b0;
      sync_err_o <= 1'b0;
      ka_cnt_o   <= '0;
    end else begin
      ln_q       <= line_i;
      push_o     <= 1'b0;
      eop_o      <= 1'b0;
      ovf_o      <= 1'b0;
      sync_err_o <= 1'b0;
      ph         <= (ph == PH_W'(OSR - 1)) ? '0 : ph + 1'b1;
      unique case (st)
        ST_HUNT: begin
          if (jk_edge) begin
            st     <= ST_SYNC;
            ph     <= PH_W'(1);
            last_k <= 1'b0;
          end else if (ln_q == LN_J && line_i == LN_SE0) begin
            st <= ST_KALIVE;
            if (ka_cnt_o != KA_MAX) ka_cnt_o <= ka_cnt_o + 1'b1;
          end
        end
        ST_KALIVE: if (line_i == LN_J) st <= ST_HUNT;
        ST_SYNC: begin
          if (smp) begin
            if (line_i == LN_SE0) begin
              sync_err_o <= 1'b1;
              st         <= ST_HUNT;
            end else if (line_i == LN_K) begin
              if (last_k) begin
                st      <= ST_DATA;
                prev_dm <= 1'b0;
                ones    <= RUN_W'(1);
                bpos    <= '0;
              end
              last_k <= 1'b1;
            end else begin
              last_k <= 1'b0;
            end
          end
          if (jk_edge) ph <= PH_W'(1);
        end
        ST_DATA: begin
          if (smp) begin
            if (line_i == LN_SE0 && bpos != '0) begin
              eop_o <= 1'b1;
              st    <= ST_HUNT;
            end else begin
              prev_dm <= line_i[0];
              if (ones == RUN_W'(STUFF_RUN)) begin
                ones <= '0;
              end else begin
                shreg <= nbyte;
                ones  <= dbit ? ones + 1'b1 : '0;
                bpos  <= bpos + 1'b1;
                if (bpos == BIT_W'(BYTE_BITS - 1)) begin
                  if (full_i) begin
                    ovf_o <= 1'b1;
                    st    <= ST_DRAIN;
                  end else begin
                    push_o <= 1'b1;
                    byte_o <= nbyte;
                  end
                end
              end
            end
          end
        end
        ST_DRAIN: if (line_i == LN_SE0) st <= ST_HUNT;
        default: st <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int unsigned OSR        = 10,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned KA_W       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dp_i,
  input  logic            dm_i,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [7:0]      rx_data,
  output logic            eop,
  output logic            ovf_err,
  output logic            sync_err,
  output logic [KA_W-1:0] ka_cnt
);
  logic [1:0]           line_s;
  logic                 push, full;
  logic [BYTE_BITS-1:0] push_byte;

  usb_ls_rx_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({dp_i, dm_i}), .q_o(line_s)
  );

  usb_ls_rx_core #(.OSR(OSR), .KA_W(KA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .line_i(line_t'(line_s)), .full_i(full),
    .push_o(push), .byte_o(push_byte), .eop_o(eop), .ovf_o(ovf_err),
    .sync_err_o(sync_err), .ka_cnt_o(ka_cnt)
  );

  usb_ls_rx_fifo #(.WIDTH(BYTE_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(push_byte),
    .full_o(full), .valid_o(rx_valid), .ready_i(rx_ready), .data_o(rx_data)
  );
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int unsigned KA_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      line_s,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [7:0]      rx_data,
  input logic            eop,
  input logic            ovf_err,
  input logic            sync_err,
  input logic [KA_W-1:0] ka_cnt
);
  localparam logic [KA_W-1:0] KA_TOP = '1;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({eop, ovf_err, sync_err}) <= 1); // R11

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R7

  AST_KA_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    ka_cnt == KA_TOP |=> ka_cnt == KA_TOP); // R9

  AST_KA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ka_cnt != KA_TOP |=> (ka_cnt == $past(ka_cnt)) || (ka_cnt == $past(ka_cnt) + 1'b1)); // R9

  AST_EOP_ON_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> $past(line_s) == 2'b00); // R6

  AST_SYNC_ERR_ON_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(line_s) == 2'b00); // R10
endmodule

bind usb_ls_rx usb_ls_rx_chk #(.KA_W(KA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_s(line_s), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .eop(eop), .ovf_err(ovf_err),
  .sync_err(sync_err), .ka_cnt(ka_cnt)
);

// File: tb/sim_usb_ls_rx.sv
`timescale 1ns/1ps
module sim_usb_ls_rx;
  localparam int OSR = 10;
  localparam int DEP = 4;
  localparam int KAW = 2;
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b1, rx_ready = 1'b1;
  logic rx_valid, eop, ovf_err, sync_err;
  logic [7:0] rx_data;
  logic [KAW-1:0] ka_cnt;

  always #5 clk = ~clk;

  usb_ls_rx #(.OSR(OSR), .FIFO_DEPTH(DEP), .KA_W(KAW)) u0 (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .eop(eop), .ovf_err(ovf_err),
    .sync_err(sync_err), .ka_cnt(ka_cnt)
  );

  int checks = 0, errors = 0;
  int got_n = 0, eop_n = 0, ovf_n = 0, serr_n = 0;
  logic [7:0] got [0:1023];
  logic [7:0] pkt [0:7];
  logic [1:0] cur;
  int ones;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && rx_ready) begin got[got_n] = rx_data; got_n = got_n + 1; end
      if (eop) eop_n = eop_n + 1;
      if (ovf_err) ovf_n = ovf_n + 1;
      if (sync_err) serr_n = serr_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic [1:0] ln, input int len);
    dp = ln[1]; dm = ln[0];
    repeat (len) @(negedge clk);
  endtask

  function automatic logic [1:0] flip(input logic [1:0] l);
    return (l == LJ) ? LK : LJ;
  endfunction

  // sync, n bytes with stuffing, optional cut bits, optional dribble, EOP
  task automatic send_pkt(input int n, input int cut, input bit drib, input int slen);
    cur = LJ;
    for (int i = 0; i < 7; i++) begin cur = flip(cur); bit_out(cur, (i < 6) ? slen : OSR); end
    bit_out(cur, OSR);
    ones = 1;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        if (pkt[i][b]) ones++; else begin ones = 0; cur = flip(cur); end
        bit_out(cur, OSR);
        if (ones == 6) begin cur = flip(cur); bit_out(cur, OSR); ones = 0; end
      end
    for (int i = 0; i < cut; i++) begin cur = flip(cur); bit_out(cur, OSR); end
    if (drib) bit_out(cur, OSR);
    bit_out(LSE0, OSR); bit_out(LSE0, OSR); bit_out(LJ, 4 * OSR);
  endtask

  task automatic expect_pkt(input int n, input int base, input int e0, input string tag);
    chk(got_n - base == n, {tag, " byte count"}, got_n - base, n);
    for (int i = 0; i < n; i++)
      chk(got[base + i] == pkt[i], {tag, " byte value"}, got[base + i], pkt[i]);
    chk(eop_n - e0 == 1, {tag, " eop"}, eop_n - e0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base, e0, o0, s0;
    repeat (3) @(negedge clk);
    chk(!rx_valid && !eop && !ovf_err && !sync_err, "R1 reset outputs", {rx_valid, eop, ovf_err, sync_err}, 0);
    chk(ka_cnt == 0, "R1 reset ka_cnt", ka_cnt, 0);
    rst_n = 1'b1;
    bit_out(LJ, 3 * OSR);

    // R4 R7 R2 R3: every byte value, consumer stalled on odd packets
    for (int p = 0; p < 64; p++) begin
      for (int i = 0; i < 4; i++) pkt[i] = 8'(p * 4 + i);
      base = got_n; e0 = eop_n;
      rx_ready = (p % 2 == 0);
      send_pkt(4, 0, 0, OSR);
      rx_ready = 1'b1;
      bit_out(LJ, 2 * OSR);
      expect_pkt(4, base, e0, "R4/R7 sweep");
    end

    // R5: long one runs, stuffing across byte boundaries and at packet end
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'hFF;
    base = got_n; e0 = eop_n;
    send_pkt(4, 0, 0, OSR);
    expect_pkt(4, base, e0, "R5 stuffing");
    pkt[0] = 8'hFC; pkt[1] = 8'h3F; pkt[2] = 8'h80;
    base = got_n; e0 = eop_n;
    send_pkt(3, 0, 0, OSR);
    expect_pkt(3, base, e0, "R5 stuffing run");

    // R6: dribble bit tolerated
    pkt[0] = 8'hA5; pkt[1] = 8'h3C;
    base = got_n; e0 = eop_n;
    send_pkt(2, 0, 1, OSR);
    expect_pkt(2, base, e0, "R6 dribble");

    // R6: SE0 inside a byte drops partial byte
    pkt[0] = 8'h5A;
    base = got_n; e0 = eop_n;
    send_pkt(1, 3, 0, OSR);
    expect_pkt(1, base, e0, "R6 mid-byte SE0");

    // R3 R2: stretched sync bits
    pkt[0] = 8'hC3; pkt[1] = 8'h01;
    base = got_n; e0 = eop_n;
    send_pkt(2, 0, 0, 13);
    expect_pkt(2, base, e0, "R3 stretched sync");

    // R8: overflow with stalled consumer
    for (int i = 0; i < 6; i++) pkt[i] = 8'(8'h90 + i);
    base = got_n; e0 = eop_n; o0 = ovf_n;
    rx_ready = 1'b0;
    send_pkt(6, 0, 0, OSR);
    chk(ovf_n - o0 == 1, "R8 ovf pulse", ovf_n - o0, 1);
    chk(eop_n == e0, "R8 no eop", eop_n - e0, 0);
    rx_ready = 1'b1;
    bit_out(LJ, OSR);
    chk(got_n - base == DEP, "R8 kept bytes", got_n - base, DEP);
    for (int i = 0; i < DEP; i++)
      chk(got[base + i] == pkt[i], "R8 kept value", got[base + i], pkt[i]);
    pkt[0] = 8'h11;
    base = got_n; e0 = eop_n;
    send_pkt(1, 0, 0, OSR);
    expect_pkt(1, base, e0, "R8 recovery");

    // R10: SE0 during sync
    base = got_n; e0 = eop_n; s0 = serr_n;
    bit_out(LK, OSR); bit_out(LJ, OSR); bit_out(LK, OSR);
    bit_out(LSE0, OSR); bit_out(LSE0, OSR); bit_out(LJ, 4 * OSR);
    chk(serr_n - s0 == 1, "R10 sync_err", serr_n - s0, 1);
    chk(eop_n == e0 && got_n == base, "R10 no packet", eop_n - e0, 0);

    // R9: keep-alives with saturation
    for (int k = 1; k <= 5; k++) begin
      base = got_n; e0 = eop_n;
      bit_out(LSE0, OSR); bit_out(LSE0, OSR); bit_out(LJ, 3 * OSR);
      chk(ka_cnt == ((k > 3) ? 3 : k), "R9 ka_cnt", ka_cnt, (k > 3) ? 3 : k);
      chk(eop_n == e0 && got_n == base, "R9 no packet", eop_n - e0, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule